// File: doc/BRIEF.md
# DMA Channel Request Scheduler

This block decides which DMA channel performs the next single-element move. Each channel presents its configuration word and its remaining element count. The block also sees a controller-wide enable and two vectors of peripheral request lines, one for single requests and one for burst requests. It qualifies every channel and scans them in ascending order. It then hands one channel at a time to a transfer engine. The grant stays up until the engine reports that the element is done.

In each configuration word, a three-bit flow field states which peripheral handshakes the channel waits for. A memory-to-memory channel needs none. The other kinds need the destination line, the source line, or both, and each line is picked by a five-bit peripheral number. Flow codes that would hand control to a peripheral are not handled here. A channel that carries one of those codes raises an error flag when the scan reaches it, and it is not granted.

Top module: `dma_req_sched`

## Requirements
- R1: After reset, grant_vld and flow_err are 0 and grant_ch is 0; the scan pointer starts at channel 0.
- R2: While ctl_en is 0, no grant is issued and flow_err stays 0.
- R3: A channel is a candidate only when configuration bit 0 (channel enable) is 1 and configuration bit 18 (halt) is 0.
- R4: Configuration bits [13:11] are the flow code, bits [5:1] the source peripheral number and bits [10:6] the destination peripheral number. Flow 0 needs no request, flow 1 needs the destination line, flow 2 needs the source line and flow 3 needs both.
- R5: A peripheral line counts as active when its bit is set in either req_single or req_burst. A peripheral number at or above REQ_N counts as inactive.
- R6: A channel whose remaining count is zero is never granted.
- R7: An active channel with flow code 4 to 7 that is reached first in the scan raises flow_err for one cycle instead of a grant. The scan then resumes at the next higher index in the following cycle.
- R8: A grant holds grant_vld and grant_ch steady until xfer_done. In the cycle after xfer_done, grant_vld is 0 and a new decision is made, and its grant shows one cycle later.
- R9: The scan begins at the channel granted last. That channel is granted again while it stays eligible. Otherwise the next eligible higher index wins, wrapping to the lowest eligible index.
- R10: xfer_done has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller-wide enable |
| ch_cfg | input | NUM_CH*19 | Per-channel configuration words, channel i at [i*19 +: 19] |
| ch_count | input | NUM_CH*CNT_W | Per-channel remaining element counts |
| req_single | input | REQ_N | Single-request lines from peripherals |
| req_burst | input | REQ_N | Burst-request lines from peripherals |
| xfer_done | input | 1 | Engine finished the granted element |
| grant_vld | output | 1 | A channel is granted |
| grant_ch | output | $clog2(NUM_CH) | Index of the granted channel |
| flow_err | output | 1 | Scan reached a channel with an unsupported flow code |

## Verification
Each flow code is tried with only the wrong request line active, then with the right line on the single or the burst vector. This separates the source-number field from the destination-number field and shows that the OR of the two request vectors is used. A rotation pattern uses three ready channels whose counts run out one after another. It shows whether the pointer stays on the current channel, moves upward, or wraps to the lowest index rather than to the next one. Separate patterns clear the enable, halt and count qualifiers one at a time, and place a bad flow code ahead of a good channel, so that each veto can be seen apart from the others.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;

   // configuration word layout (decoded by the channel register block)
   localparam int CFG_W        = 19;
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_SRC_LSB  = 1;
   localparam int CFG_DST_LSB  = 6;
   localparam int CFG_FLOW_LSB = 11;
   localparam int CFG_HALT_BIT = 18;
   localparam int PER_W        = 5;
   localparam int FLOW_W       = 3;

   typedef enum logic [FLOW_W-1:0] {
      FLOW_MEM2MEM = 3'd0,
      FLOW_TO_PER  = 3'd1,
      FLOW_FROM_PER= 3'd2,
      FLOW_PER2PER = 3'd3
   } flow_e;

   typedef struct packed {
      logic              halt;
      logic [3:0]        rsvd;
      logic [FLOW_W-1:0] flow;
      logic [PER_W-1:0]  dst;
      logic [PER_W-1:0]  src;
      logic              en;
   } ch_cfg_t;

endpackage

// File: rtl/dma_chan_qualify.sv
module dma_chan_qualify
   import dma_sched_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 12,
   parameter int REQ_N  = 32
) (
   input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
   input  logic [NUM_CH*CNT_W-1:0] ch_count,
   input  logic [REQ_N-1:0]        req_single,
   input  logic [REQ_N-1:0]        req_burst,
   output logic [NUM_CH-1:0]       elig,
   output logic [NUM_CH-1:0]       bad_flow
);

   logic [REQ_N-1:0] req_any;
   assign req_any = req_single | req_burst;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      ch_cfg_t          cfg;
      logic             active;
      logic             cnt_nz;
      logic             src_on;
      logic             dst_on;
      logic             need_ok;

      assign cfg    = ch_cfg[i*CFG_W +: CFG_W];
      assign active = cfg.en & ~cfg.halt;
      assign cnt_nz = |ch_count[i*CNT_W +: CNT_W];

      if (REQ_N == 32) begin : g_full
         assign src_on = req_any[cfg.src];
         assign dst_on = req_any[cfg.dst];
      end else begin : g_part
         always_comb begin
            src_on = 1'b0;
            dst_on = 1'b0;
            for (int l = 0; l < REQ_N; l++) begin
               if (int'(cfg.src) == l) src_on = req_any[l];
               if (int'(cfg.dst) == l) dst_on = req_any[l];
            end
         end
      end

      always_comb begin
         case (cfg.flow)
            FLOW_MEM2MEM:  need_ok = 1'b1;
            FLOW_TO_PER:   need_ok = dst_on;
            FLOW_FROM_PER: need_ok = src_on;
            FLOW_PER2PER:  need_ok = src_on & dst_on;
            default:       need_ok = 1'b0;
         endcase
      end

      assign elig[i]     = active & cnt_nz & ~cfg.flow[2] & need_ok;
      assign bad_flow[i] = active & cfg.flow[2];
   end

endmodule

// File: rtl/dma_rr_pick.sv
module dma_rr_pick #(
   parameter int NUM_CH = 8,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH-1:0] cand,
   input  logic [IDX_W-1:0]  start,
   output logic              found,
   output logic [IDX_W-1:0]  pick
);

   // first set bit of cand at or above start, wrapping to index 0
   always_comb begin
      found = 1'b0;
      pick  = start;
      for (int k = 0; k < NUM_CH; k++) begin
         int idx;
         idx = (int'(start) + k) % NUM_CH;
         if (!found && cand[idx]) begin
            found = 1'b1;
            pick  = IDX_W'(idx);
         end
      end
   end

endmodule

// File: rtl/dma_req_sched.sv
module dma_req_sched
   import dma_sched_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CNT_W  = 12,
   parameter int REQ_N  = 32,
   localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ctl_en,
   input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
   input  logic [NUM_CH*CNT_W-1:0] ch_count,
   input  logic [REQ_N-1:0]        req_single,
   input  logic [REQ_N-1:0]        req_burst,
   input  logic                    xfer_done,
   output logic                    grant_vld,
   output logic [IDX_W-1:0]        grant_ch,
   output logic                    flow_err
);

   initial begin
      assert (NUM_CH >= 1 && NUM_CH <= 32) else $error("NUM_CH out of range");
      assert (REQ_N >= 1 && REQ_N <= 32)   else $error("REQ_N out of range");
      assert (CNT_W >= 1)                  else $error("CNT_W must be positive");
   end

   logic [NUM_CH-1:0] elig;
   logic [NUM_CH-1:0] bad_flow;
   logic [IDX_W-1:0]  ptr_q;
   logic              found;
   logic [IDX_W-1:0]  pick;
   logic              decide;
   logic [IDX_W-1:0]  pick_nxt;

   dma_chan_qualify #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .REQ_N(REQ_N)) u_qual (
      .ch_cfg     (ch_cfg),
      .ch_count   (ch_count),
      .req_single (req_single),
      .req_burst  (req_burst),
      .elig       (elig),
      .bad_flow   (bad_flow)
   );

   dma_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
      .cand  (elig | bad_flow),
      .start (ptr_q),
      .found (found),
      .pick  (pick)
   );

   assign decide   = ~grant_vld & ctl_en & found;
   assign pick_nxt = (int'(pick) == NUM_CH-1) ? '0 : pick + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant_vld <= 1'b0;
         grant_ch  <= '0;
         flow_err  <= 1'b0;
         ptr_q     <= '0;
      end else begin
         flow_err <= 1'b0;
         if (grant_vld) begin
            if (xfer_done) grant_vld <= 1'b0;
         end else if (decide) begin
            if (bad_flow[pick]) begin
               flow_err <= 1'b1;
               ptr_q    <= pick_nxt;
            end else begin
               grant_vld <= 1'b1;
               grant_ch  <= pick;
               ptr_q     <= pick;
            end
         end
      end
   end

   // R2: a new grant only follows a cycle with the controller enabled
   a_r2_grant_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grant_vld) |-> $past(ctl_en));

   // R7: an unsupported-flow report never coincides with a grant
   a_r7_err_excludes_grant: assert property (@(posedge clk) disable iff (!rst_n)
      flow_err |-> !grant_vld);

   // R8: grant held steady until done
   a_r8_grant_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld && !xfer_done) |=> (grant_vld && $stable(grant_ch)));

   // R8: done drops the grant for one decision cycle
   a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_vld && xfer_done) |=> !grant_vld);

   // R10: done while idle and disabled leaves the block idle
   a_r10_idle_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!grant_vld && xfer_done && !ctl_en) |=> !grant_vld);

   // R9: granted index always names an implemented channel
   a_r9_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld |-> (int'(grant_ch) < NUM_CH));

endmodule

// File: tb/sim_dma_req_sched.sv
`timescale 1ns/1ps
module sim_dma_req_sched;
   localparam int NUM_CH = 8;
   localparam int CNT_W  = 12;
   localparam int REQ_N  = 32;
   localparam int CW     = 19;

   logic                   clk = 1'b0;
   logic                   rst_n;
   logic                   ctl_en;
   logic [NUM_CH*CW-1:0]   ch_cfg;
   logic [NUM_CH*CNT_W-1:0] ch_count;
   logic [REQ_N-1:0]       req_single;
   logic [REQ_N-1:0]       req_burst;
   logic                   xfer_done;
   logic                   grant_vld;
   logic [2:0]             grant_ch;
   logic                   flow_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit all_done = 0;

   always #2.5 clk = ~clk;

   dma_req_sched #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .REQ_N(REQ_N)) u0 (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .ch_cfg(ch_cfg),
      .ch_count(ch_count), .req_single(req_single), .req_burst(req_burst),
      .xfer_done(xfer_done), .grant_vld(grant_vld), .grant_ch(grant_ch),
      .flow_err(flow_err));

   function automatic logic [CW-1:0] mkcfg(bit en, bit halt, int flow, int src, int dst);
      logic [CW-1:0] c;
      c = '0;
      c[0]     = en;
      c[5:1]   = 5'(src);
      c[10:6]  = 5'(dst);
      c[13:11] = 3'(flow);
      c[18]    = halt;
      return c;
   endfunction

   task automatic step(int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_ch(int i, logic [CW-1:0] c, int cnt);
      ch_cfg[i*CW +: CW]         = c;
      ch_count[i*CNT_W +: CNT_W] = CNT_W'(cnt);
   endtask

   task automatic set_cnt(int i, int cnt);
      ch_count[i*CNT_W +: CNT_W] = CNT_W'(cnt);
   endtask

   task automatic chk(string tag, bit vld_e, int ch_e, bit err_e);
      n_chk++;
      if (grant_vld !== vld_e || flow_err !== err_e ||
          (vld_e && int'(grant_ch) != ch_e)) begin
         n_fail++;
         $display("FAIL %s: got vld=%0b ch=%0d err=%0b, expected vld=%0b ch=%0d err=%0b",
                  tag, grant_vld, grant_ch, flow_err, vld_e, ch_e, err_e);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ctl_en = 1'b0; ch_cfg = '0; ch_count = '0;
      req_single = '0; req_burst = '0; xfer_done = 1'b0;
      step(2);
      rst_n = 1'b1; ctl_en = 1'b1;
   endtask

   // done pulse seen by one edge; grant low after it, new grant one edge later
   task automatic pulse_done(string tag, int ch_e);
      xfer_done = 1'b1;
      step();
      xfer_done = 1'b0;
      chk({tag, " low after done"}, 1'b0, 0, 1'b0);
      step();
      chk({tag, " next grant"}, 1'b1, ch_e, 1'b0);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 reset state", 1'b0, 0, 1'b0);
   endtask

   task automatic t_enable();
      do_reset();
      ctl_en = 1'b0;
      set_ch(2, mkcfg(1, 0, 0, 0, 0), 5);
      step(3);
      chk("R2 disabled no grant", 1'b0, 0, 1'b0);
      xfer_done = 1'b1;           // R10: idle done
      step();
      xfer_done = 1'b0;
      step();
      chk("R10 idle done ignored", 1'b0, 0, 1'b0);
      ctl_en = 1'b1;
      step();
      chk("R2 grant once enabled", 1'b1, 2, 1'b0);
   endtask

   task automatic t_halt();
      do_reset();
      set_ch(1, mkcfg(0, 0, 0, 0, 0), 1);
      set_ch(3, mkcfg(1, 1, 0, 0, 0), 1);
      step(3);
      chk("R3 disabled/halted skipped", 1'b0, 0, 1'b0);
      set_ch(3, mkcfg(1, 0, 0, 0, 0), 1);
      step();
      chk("R3 unhalted granted", 1'b1, 3, 1'b0);
   endtask

   task automatic t_flow();
      do_reset();
      set_ch(0, mkcfg(1, 0, 1, 4, 7), 3);
      step(2);
      chk("R4 flow1 no request", 1'b0, 0, 1'b0);
      req_single[4] = 1'b1;
      step(2);
      chk("R4 flow1 source line only", 1'b0, 0, 1'b0);
      req_burst[7] = 1'b1;
      step();
      chk("R5 flow1 dest via burst", 1'b1, 0, 1'b0);

      do_reset();
      set_ch(5, mkcfg(1, 0, 2, 9, 20), 3);
      req_single[20] = 1'b1;
      step(2);
      chk("R4 flow2 dest line only", 1'b0, 0, 1'b0);
      req_burst[9] = 1'b1;
      step();
      chk("R4 flow2 source line", 1'b1, 5, 1'b0);

      do_reset();
      set_ch(7, mkcfg(1, 0, 3, 31, 0), 3);
      req_single[31] = 1'b1;
      step(2);
      chk("R4 flow3 one line", 1'b0, 0, 1'b0);
      req_single[0] = 1'b1;
      step();
      chk("R5 flow3 both single", 1'b1, 7, 1'b0);
   endtask

   task automatic t_count();
      do_reset();
      set_ch(2, mkcfg(1, 0, 0, 0, 0), 0);
      step(3);
      chk("R6 zero count", 1'b0, 0, 1'b0);
      set_cnt(2, 1);
      step();
      chk("R6 nonzero count", 1'b1, 2, 1'b0);
   endtask

   task automatic t_flow_err();
      do_reset();
      set_ch(1, mkcfg(1, 0, 5, 0, 0), 0);
      set_ch(4, mkcfg(1, 0, 0, 0, 0), 2);
      step();
      chk("R7 error flagged", 1'b0, 0, 1'b1);
      step();
      chk("R7 scan resumes past bad", 1'b1, 4, 1'b0);
   endtask

   task automatic t_hold();
      do_reset();
      set_ch(2, mkcfg(1, 0, 0, 0, 0), 3);
      step();
      chk("R8 granted", 1'b1, 2, 1'b0);
      set_ch(6, mkcfg(1, 0, 0, 0, 0), 3);
      set_cnt(2, 0);
      step(4);
      chk("R8 held without done", 1'b1, 2, 1'b0);
      set_cnt(2, 3);
      pulse_done("R8 regrant", 2);
   endtask

   task automatic t_scan();
      do_reset();
      set_ch(1, mkcfg(1, 0, 0, 0, 0), 2);
      set_ch(3, mkcfg(1, 0, 0, 0, 0), 2);
      set_ch(6, mkcfg(1, 0, 0, 0, 0), 2);
      step();
      chk("R9 lowest from pointer 0", 1'b1, 1, 1'b0);
      pulse_done("R9 stays on channel", 1);
      set_cnt(1, 0);
      pulse_done("R9 moves up to 3", 3);
      set_cnt(3, 0); set_cnt(1, 4);
      pulse_done("R9 moves up to 6", 6);
      set_cnt(6, 0); set_cnt(3, 4);
      pulse_done("R9 wraps to lowest", 1);
   endtask

   initial begin
      t_reset();
      t_enable();
      t_halt();
      t_flow();
      t_count();
      t_flow_err();
      t_hold();
      t_scan();
      all_done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!all_done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule